// File: doc/BRIEF.md
# Strided Block Copier

This block moves a run of bytes from one region of memory to another over a narrow byte-wide memory bus. Five 16-bit working registers control it: a byte count, a source pointer, a destination pointer, a source step and a destination step. Each byte is moved in two bus phases. The first phase reads at the source pointer. The second phase writes the fetched byte at the destination pointer. Both pointers then advance by their own steps, with wraparound at 16 bits, and the count drops by one.

Between bytes the engine can yield to a pending interrupt. When it does so, the working registers already account for every byte that has been moved. The engine also presents the address of the prefix byte of the copy instruction, which is latched when the copy starts, as the place to resume from. The surrounding processor pushes that address. When the instruction is executed again, the host restarts the engine with the updated register values it reads back, and the copy picks up exactly where it stopped.

Top module: `strided_copier`

## Requirements
- R1: After synchronous reset, busy, done, susp and mem_req are all 0.
- R2: A start pulse while idle loads the count, source, destination, source step and destination step from the load inputs, and latches prefix_addr. The loaded values appear on cnt_out, src_out and dst_out in the next cycle.
- R3: Each byte uses one read phase (mem_req=1, mem_we=0, mem_addr=source) followed by one write phase (mem_req=1, mem_we=1, mem_addr=destination). Each phase holds its address and direction until a cycle in which mem_ready=1.
- R4: When a write is accepted, the source pointer gains the source step, the destination pointer gains the destination step (both modulo 2^16), and the count decreases by one.
- R5: When the count reaches zero on an accepted write, done is 1 for exactly one cycle and the engine returns to idle.
- R6: A start with a count of zero raises done in the next cycle and issues no bus phase.
- R7: irq_pend is sampled only on the cycle a write is accepted. If the count is still nonzero, susp is 1 for one cycle, the engine goes idle holding whole-byte register values, and resume_addr equals the prefix_addr latched at start.
- R8: When the final write is accepted, completion takes precedence over a pending interrupt: done is raised and susp is not.
- R9: A start pulse while busy has no effect on the registers or on the bus.
- R10: The byte driven on mem_wdata during a write phase is the byte returned on mem_rdata when that byte's read phase was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a copy from the load inputs |
| prefix_addr | input | 16 | Address of the copy instruction's prefix byte |
| cnt_in | input | 16 | Byte count to load |
| src_in | input | 16 | Source pointer to load |
| dst_in | input | 16 | Destination pointer to load |
| sstep_in | input | 16 | Source step to load |
| dstep_in | input | 16 | Destination step to load |
| irq_pend | input | 1 | Interrupt pending |
| mem_req | output | 1 | Bus phase active |
| mem_we | output | 1 | 1 = write phase, 0 = read phase |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| mem_ready | input | 1 | Current phase accepted this cycle |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| susp | output | 1 | One-cycle suspension pulse |
| resume_addr | output | 16 | Address to resume from after suspension |
| cnt_out | output | 16 | Current remaining count |
| src_out | output | 16 | Current source pointer |
| dst_out | output | 16 | Current destination pointer |

## Verification
The bench uses the default 16-bit address and 8-bit data widths. With these widths, a source pointer that starts at 0xFFF0 with a step of 5 wraps through zero, and a destination step of 0xFFFE walks backwards through memory. Both behaviours therefore come under test. The 16-bit count also makes a zero-count start and a one-byte copy with an interrupt pending cheap to set up. In those cases the order between completion and suspension decides the outcome.

// File: rtl/cpy_pkg.sv
package cpy_pkg;
    parameter int CPY_AW = 16;
    parameter int CPY_DW = 8;

    typedef logic [CPY_AW-1:0] cpy_word_t;
    typedef logic [CPY_DW-1:0] cpy_byte_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } cpy_phase_e;

    typedef struct packed {
        cpy_word_t cnt;
        cpy_word_t src;
        cpy_word_t dst;
        cpy_word_t sstep;
        cpy_word_t dstep;
    } cpy_regs_t;

    function automatic cpy_word_t cpy_advance(cpy_word_t base, cpy_word_t step);
        return base + step;
    endfunction
endpackage

// File: rtl/cpy_regfile.sv
module cpy_regfile
    import cpy_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      step,
    input  cpy_regs_t load_val,
    output cpy_regs_t regs
);
    localparam cpy_word_t ONE = cpy_word_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (load) begin
            regs <= load_val;
        end else if (step) begin
            regs.cnt <= regs.cnt - ONE;
            regs.src <= cpy_advance(regs.src, regs.sstep);
            regs.dst <= cpy_advance(regs.dst, regs.dstep);
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        step && !load |=> regs.cnt == $past(regs.cnt) - ONE);  // R4
    AST_SRC_STEP: assert property (@(posedge clk) disable iff (rst)
        step && !load |=> regs.src == $past(regs.src) + $past(regs.sstep));  // R4
    AST_DST_STEP: assert property (@(posedge clk) disable iff (rst)
        step && !load |=> regs.dst == $past(regs.dst) + $past(regs.dstep));  // R4
endmodule

// File: rtl/cpy_fsm.sv
module cpy_fsm
    import cpy_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      cnt_in_zero,
    input  cpy_word_t prefix_addr,
    input  cpy_word_t cur_cnt,
    input  cpy_word_t cur_src,
    input  cpy_word_t cur_dst,
    input  logic      irq_pend,
    input  logic      mem_ready,
    input  cpy_byte_t mem_rdata,
    output logic      load,
    output logic      step,
    output logic      mem_req,
    output logic      mem_we,
    output cpy_word_t mem_addr,
    output cpy_byte_t mem_wdata,
    output logic      busy,
    output logic      done,
    output logic      susp,
    output cpy_word_t resume_addr
);
    localparam cpy_word_t ONE = cpy_word_t'(1);

    cpy_phase_e phase, phase_nx;
    cpy_byte_t  hold_byte;
    logic       last_byte;

    assign load      = (phase == PH_IDLE) && start;
    assign step      = (phase == PH_WRITE) && mem_ready;
    assign last_byte = (cur_cnt == ONE);

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:  if (start && !cnt_in_zero) phase_nx = PH_READ;
            PH_READ:  if (mem_ready) phase_nx = PH_WRITE;
            PH_WRITE: if (mem_ready) phase_nx = (last_byte || irq_pend) ? PH_IDLE : PH_READ;
            default:  phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            hold_byte   <= '0;
            done        <= 1'b0;
            susp        <= 1'b0;
            resume_addr <= '0;
        end else begin
            phase <= phase_nx;
            done  <= (load && cnt_in_zero) || (step && last_byte);
            susp  <= step && !last_byte && irq_pend;
            if (load) resume_addr <= prefix_addr;
            if (phase == PH_READ && mem_ready) hold_byte <= mem_rdata;
        end
    end

    always_comb begin
        mem_req   = (phase == PH_READ) || (phase == PH_WRITE);
        mem_we    = (phase == PH_WRITE);
        mem_addr  = (phase == PH_WRITE) ? cur_dst : cur_src;
        mem_wdata = hold_byte;
        busy      = (phase != PH_IDLE);
    end

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));  // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R5
    AST_SUSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        susp |=> !susp && !busy);  // R7
    AST_END_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && susp));  // R8
    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && !mem_ready |=> $stable(mem_wdata));  // R10
endmodule

// File: rtl/strided_copier.sv
module strided_copier
    import cpy_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CPY_AW-1:0] prefix_addr,
    input  logic [CPY_AW-1:0] cnt_in,
    input  logic [CPY_AW-1:0] src_in,
    input  logic [CPY_AW-1:0] dst_in,
    input  logic [CPY_AW-1:0] sstep_in,
    input  logic [CPY_AW-1:0] dstep_in,
    input  logic              irq_pend,
    output logic              mem_req,
    output logic              mem_we,
    output logic [CPY_AW-1:0] mem_addr,
    output logic [CPY_DW-1:0] mem_wdata,
    input  logic [CPY_DW-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic              susp,
    output logic [CPY_AW-1:0] resume_addr,
    output logic [CPY_AW-1:0] cnt_out,
    output logic [CPY_AW-1:0] src_out,
    output logic [CPY_AW-1:0] dst_out
);
    cpy_regs_t load_val, regs;
    logic      load, step;

    always_comb begin
        load_val.cnt   = cnt_in;
        load_val.src   = src_in;
        load_val.dst   = dst_in;
        load_val.sstep = sstep_in;
        load_val.dstep = dstep_in;
    end

    cpy_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .load_val (load_val),
        .regs     (regs)
    );

    cpy_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .cnt_in_zero (cnt_in == '0),
        .prefix_addr (prefix_addr),
        .cur_cnt     (regs.cnt),
        .cur_src     (regs.src),
        .cur_dst     (regs.dst),
        .irq_pend    (irq_pend),
        .mem_ready   (mem_ready),
        .mem_rdata   (mem_rdata),
        .load        (load),
        .step        (step),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .busy        (busy),
        .done        (done),
        .susp        (susp),
        .resume_addr (resume_addr)
    );

    assign cnt_out = regs.cnt;
    assign src_out = regs.src;
    assign dst_out = regs.dst;

    AST_ZERO_START: assert property (@(posedge clk) disable iff (rst)
        start && !busy && cnt_in == '0 |=> done && !mem_req);  // R6
    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        start && busy && !(mem_we && mem_ready) |=> $stable(cnt_out));  // R9
endmodule

// File: tb/strided_copier_bench.sv
module strided_copier_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst = 1, start = 0, irq_pend = 0, mem_ready = 0;
    logic [15:0] prefix_addr = 0, cnt_in = 0, src_in = 0, dst_in = 0, sstep_in = 0, dstep_in = 0;
    logic        mem_req, mem_we, busy, done, susp;
    logic [15:0] mem_addr, resume_addr, cnt_out, src_out, dst_out;
    logic [7:0]  mem_wdata, mem_rdata;

    int n_tests = 0, n_fail = 0, cyc = 0, rdy_ctr = 0;
    logic [7:0] mem [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    strided_copier u_strided_copier (.*);

    function automatic logic [7:0] pat(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] mem_rd(logic [15:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return pat(a);
    endfunction
    assign mem_rdata = mem_rd(mem_addr);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural reference
    int          m_st = 0;
    logic [15:0] m_cnt = 0, m_src = 0, m_dst = 0, m_xs = 0, m_ys = 0, m_res = 0;
    logic [7:0]  m_data = 0;
    logic        m_done = 0, m_susp = 0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_src = 0; m_dst = 0; m_xs = 0; m_ys = 0;
            m_res = 0; m_data = 0; m_done = 0; m_susp = 0;
        end else begin
            m_done = 0; m_susp = 0;
            if (mem_req && mem_we && mem_ready) mem[int'(mem_addr)] = mem_wdata;
            case (m_st)
                0: if (start) begin
                    m_cnt = cnt_in; m_src = src_in; m_dst = dst_in;
                    m_xs = sstep_in; m_ys = dstep_in; m_res = prefix_addr;
                    if (cnt_in == 0) m_done = 1; else m_st = 1;
                end
                1: if (mem_ready) begin m_data = pat(m_src); m_st = 2; end
                default: if (mem_ready) begin
                    m_cnt = m_cnt - 1; m_src = m_src + m_xs; m_dst = m_dst + m_ys;
                    if (m_cnt == 0) begin m_done = 1; m_st = 0; end
                    else if (irq_pend) begin m_susp = 1; m_st = 0; end
                    else m_st = 1;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R3 req", mem_req, m_st != 0);
            chk("R9 busy", busy, m_st != 0);
            if (m_st != 0) begin
                chk("R3 we", mem_we, m_st == 2);
                chk("R3 addr", mem_addr, (m_st == 2) ? m_dst : m_src);
            end
            if (m_st == 2) chk("R10 wdata", mem_wdata, m_data);
            chk("R5 done", done, m_done);
            chk("R7 susp", susp, m_susp);
            chk("R4 cnt", cnt_out, m_cnt);
            chk("R4 src", src_out, m_src);
            chk("R4 dst", dst_out, m_dst);
            if (m_susp) chk("R7 resume", resume_addr, m_res);
        end
        rdy_ctr++;
        mem_ready <= (rdy_ctr % 3) != 1;
    end

    task automatic launch(logic [15:0] pa, c, s, d, xs, ys);
        @(negedge clk);
        prefix_addr = pa; cnt_in = c; src_in = s; dst_in = d; sstep_in = xs; dstep_in = ys;
        start = 1;
        @(negedge clk);
        start = 0;
        chk("R2 cnt load", cnt_out, c);
        chk("R2 src load", src_out, s);
        chk("R2 dst load", dst_out, d);
    endtask

    task automatic wait_end(output logic got_done);
        got_done = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done) begin got_done = 1; break; end
            if (susp) break;
        end
    endtask

    task automatic chk_dest(string req, logic [15:0] s, d, xs, ys, int n);
        for (int i = 0; i < n; i++)
            chk(req, mem_rd(d + 16'(i) * ys), pat(s + 16'(i) * xs));
    endtask

    initial begin
        while (cyc < 100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic gd;
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0); chk("R1 done", done, 0);
        chk("R1 susp", susp, 0); chk("R1 req", mem_req, 0);
        rst = 0;

        // plain contiguous copy
        launch(16'h0400, 16'd6, 16'h1000, 16'h2000, 16'd1, 16'd1);
        wait_end(gd);
        chk("R5 done reached", gd, 1);
        chk_dest("R10 contiguous", 16'h1000, 16'h2000, 16'd1, 16'd1, 6);
        @(negedge clk);
        chk("R4 final cnt", cnt_out, 0);
        chk("R4 final src", src_out, 16'h1006);
        chk("R4 final dst", dst_out, 16'h2006);

        // strided with wrap and a backwards destination
        launch(16'h0410, 16'd8, 16'hFFF0, 16'h3000, 16'd5, 16'hFFFE);
        wait_end(gd);
        chk("R5 strided done", gd, 1);
        chk_dest("R4 strided", 16'hFFF0, 16'h3000, 16'd5, 16'hFFFE, 8);
        chk("R4 wrap src", src_out, 16'h0018);
        chk("R4 back dst", dst_out, 16'h2FF0);

        // zero count
        launch(16'h0420, 16'd0, 16'h5000, 16'h6000, 16'd1, 16'd1);
        chk("R6 done next", done, 1);
        chk("R6 no req", mem_req, 0);
        chk("R6 idle", busy, 0);

        // interrupt, then restart from read-back registers
        launch(16'h0A37, 16'd10, 16'h4000, 16'h7000, 16'd2, 16'd3);
        while (cnt_out > 16'd7) @(negedge clk);
        irq_pend = 1;
        start = 1;  // start while busy: ignored (R9)
        cnt_in = 16'd99; src_in = 16'h0; dst_in = 16'h0;
        @(negedge clk);
        start = 0;
        wait_end(gd);
        irq_pend = 0;
        chk("R7 suspended", gd, 0);
        chk("R7 resume addr", resume_addr, 16'h0A37);
        chk("R7 whole bytes", src_out - 16'h4000, (16'd10 - cnt_out) * 16'd2);
        @(negedge clk);
        chk("R7 idle after susp", busy, 0);
        launch(16'h0A37, cnt_out, src_out, dst_out, 16'd2, 16'd3);
        wait_end(gd);
        chk("R7 restart done", gd, 1);
        chk_dest("R7 restart data", 16'h4000, 16'h7000, 16'd2, 16'd3, 10);

        // interrupt on the last byte
        irq_pend = 1;
        launch(16'h0B00, 16'd1, 16'h4800, 16'h7800, 16'd1, 16'd1);
        wait_end(gd);
        irq_pend = 0;
        chk("R8 done wins", gd, 1);
        chk("R8 no susp", susp, 0);
        chk_dest("R8 byte", 16'h4800, 16'h7800, 16'd1, 16'd1, 1);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule